// File: doc/BRIEF.md
# Guarded Serial Pattern Detector

This block watches a serial bit stream, one bit per accepted clock cycle, and raises a one-bit detect output in the cycle where the accepted bit completes the pattern 010. Detection is guarded by a second pattern. Once the bits accepted since reset have ever contained 100, the machine falls into an absorbing lock state. From then on it never raises the detect output again until a synchronous reset returns it to its start state.

The machine is a Mealy design. The detect output is a function of the present state and the bit offered in the current cycle, so a match is reported in the same cycle its last bit is accepted. The state lives in three registers with a fixed binary code:

| State | Code | Meaning |
|---|---|---|
| start | 000 | start |
| "0" | 001 | last accepted bit was 0 |
| "01" | 010 | last accepted bits were 01 |
| "10" after a match | 011 | last accepted bits were 10, reached by completing 010 |
| "1" | 100 | last accepted bit was 1 |
| "10" otherwise | 101 | last accepted bits were 10, reached any other way |
| lock | 110 | lock |

The code 111 is never used. If it is ever reached, the next accepted bit sends the machine to the start state with the output low.

Input uses a valid/ready handshake. A bit is accepted when `in_valid` and `in_ready` are both high in the same cycle. The block applies no back-pressure in normal operation. `in_ready` is low only while reset is asserted. A bit offered while `in_ready` is low is dropped, and it is not held for later.

Top module: `gpd_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to the start state. During that cycle `in_ready` and `det_o` are both 0.
- R2: `det_o` is 1 in a cycle exactly when a bit is accepted in that cycle, the accepted bits since reset (including this one) end in 010, and 100 has never appeared among them.
- R3: Matches may overlap. The closing 0 of one 010 can start the next match, so the stream 01010 gives `det_o`=1 on its third and fifth bits.
- R4: After 100 has been accepted, `det_o` stays 0 for every later bit until reset. For example, 110110010 followed by 010 never raises it.
- R5: A reset issued after the lock re-enables detection. A following 010 raises `det_o` on its last bit.
- R6: In a cycle with `in_valid` low, the state does not change and `det_o` is 0. Data offered in such cycles has no effect on later detection.
- R7: `in_ready` is 1 in every cycle where `rst` is 0.
- R8: The output is Mealy. In the state reached after accepting 01, an offered 0 gives `det_o`=1 in that same cycle, while an offered 1 gives 0.
- R9: After reset, the stream 00011010 gives `det_o`=1 on its final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A serial bit is offered this cycle |
| in_data | input | 1 | The offered serial bit |
| in_ready | output | 1 | Bit is accepted when high together with in_valid |
| det_o | output | 1 | Pattern 010 completed by the bit accepted this cycle |

## Verification
Two functions can meet in one cycle: the synchronous reset and the acceptance of a bit that would complete 010 or 100. The bench provokes this by offering such a bit while `rst` is high. It then expects the reset to win: `in_ready` and `det_o` low, and the bit absent from later history. The random phase mixes resets, valid gaps and bits freely. A behavioural model, built on a bit queue and a sticky flag for 100, judges `det_o` and `in_ready` in every cycle.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_Z    = 3'd1,
    ST_ZO   = 3'd2,
    ST_ZOZ  = 3'd3,
    ST_O    = 3'd4,
    ST_OZ   = 3'd5,
    ST_LOCK = 3'd6
  } gpd_state_e;
endpackage

// File: rtl/gpd_next_state.sv
module gpd_next_state
  import gpd_pkg::*;
(
  input  gpd_state_e cur_i,
  input  logic       take_i,
  input  logic       bit_i,
  output gpd_state_e nxt_o,
  output logic       hit_o
);
  always_comb begin
    nxt_o = cur_i;
    hit_o = 1'b0;
    if (take_i) begin
      unique case (cur_i)
        ST_IDLE: nxt_o = bit_i ? ST_O  : ST_Z;
        ST_Z:    nxt_o = bit_i ? ST_ZO : ST_Z;
        ST_ZO: begin
          nxt_o = bit_i ? ST_O : ST_ZOZ;
          hit_o = ~bit_i;
        end
        ST_ZOZ:  nxt_o = bit_i ? ST_ZO : ST_LOCK;
        ST_O:    nxt_o = bit_i ? ST_O  : ST_OZ;
        ST_OZ:   nxt_o = bit_i ? ST_ZO : ST_LOCK;
        ST_LOCK: nxt_o = ST_LOCK;
        default: nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpd_state_reg.sv
module gpd_state_reg
  import gpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  gpd_state_e d_i,
  output gpd_state_e q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= ST_IDLE;
    else if (load_i) q_o <= d_i;
  end

  AST_RESET_TO_IDLE: assert property (@(posedge clk) rst |=> (q_o == ST_IDLE)); // R1
endmodule

// File: rtl/gpd_detector.sv
module gpd_detector
  import gpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_data,
  output logic in_ready,
  output logic det_o
);
  localparam logic [ST_W-1:0] UNUSED_CODE = {ST_W{1'b1}};

  gpd_state_e state_q;
  gpd_state_e state_d;
  logic       accept;
  logic       hit;
  logic [ST_W-1:0] state_code;

  assign in_ready   = ~rst;
  assign accept     = in_valid & in_ready;
  assign state_code = state_q;

  gpd_next_state u_next (
    .cur_i  (state_q),
    .take_i (accept),
    .bit_i  (in_data),
    .nxt_o  (state_d),
    .hit_o  (hit)
  );

  gpd_state_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  assign det_o = hit;

  AST_LOCK_STICKY:    assert property (@(posedge clk) disable iff (rst) (state_q == ST_LOCK) |=> (state_q == ST_LOCK)); // R4
  AST_LOCK_SILENT:    assert property (@(posedge clk) disable iff (rst) (state_q == ST_LOCK) |-> !det_o); // R4
  AST_HOLD_IDLE_BIT:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(state_q)); // R6
  AST_DET_NEEDS_BIT:  assert property (@(posedge clk) disable iff (rst) det_o |-> (in_valid && in_ready)); // R6
  AST_DET_OVERLAP:    assert property (@(posedge clk) disable iff (rst) det_o |=> (state_q == ST_ZOZ)); // R3
  AST_READY_OUT_RST:  assert property (@(posedge clk) !rst |-> in_ready); // R7
  AST_LEGAL_CODE:     assert property (@(posedge clk) disable iff (rst) state_code != UNUSED_CODE); // R2
endmodule

// File: tb/gpd_detector_tb.sv
`timescale 1ns/1ps
module gpd_detector_tb;
  logic clk = 1'b0;
  logic rst, in_valid, in_data;
  logic in_ready, det_o;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   hist[$];
  bit   seen_bad = 1'b0;

  always #5 clk = ~clk;

  gpd_detector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .det_o(det_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare before the rising edge, then update the model.
  task automatic step(input logic r, input logic v, input logic d, input string req);
    logic exp_det;
    logic exp_rdy;
    int   n;
    @(negedge clk);
    rst = r; in_valid = v; in_data = d;
    #4;
    exp_rdy = !r;
    exp_det = 1'b0;
    n = hist.size();
    if (!r && v && !seen_bad && n >= 2)
      exp_det = (hist[n-2] == 1'b0) && (hist[n-1] == 1'b1) && (d == 1'b0);
    check({req, " ready"}, in_ready, exp_rdy);
    check({req, " det"}, det_o, exp_det);
    if (r) begin
      hist.delete();
      seen_bad = 1'b0;
    end else if (v) begin
      hist.push_back(d);
      n = hist.size();
      if (n >= 3 && hist[n-3] == 1'b1 && hist[n-2] == 1'b0 && hist[n-1] == 1'b0)
        seen_bad = 1'b1;
      if (n > 3) void'(hist.pop_front());
    end
  endtask

  task automatic send(input string bits, input string req);
    for (int i = 0; i < bits.len(); i++)
      step(1'b0, 1'b1, bits[i] == "1", req);
  endtask

  task automatic do_reset();
    step(1'b1, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = 1'b0;
    // R1: reset state, including a completing bit offered during reset
    do_reset();
    step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, "R7");
    // R9: reference stream ends in a detect
    send("0001101", "R9");
    n_tests++;
    step(1'b0, 1'b1, 1'b0, "R9");
    if (det_o !== 1'b1) begin n_fail++; $display("FAIL R9: actual %0b expected 1", det_o); end
    // R3: overlapping matches
    do_reset();
    send("01010", "R3");
    // R4: lock after 100, silent afterwards
    do_reset();
    send("110110010", "R4");
    send("010010", "R4");
    // R5: reset clears the lock
    do_reset();
    send("010", "R5");
    // R1 vs accept in same cycle: reset wins, the 0 is not recorded
    send("01", "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    send("0", "R1");
    // R6: bits offered with valid low are ignored
    do_reset();
    send("0", "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    send("1", "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    send("0", "R6");
    // R8: Mealy dependence on the current bit
    do_reset();
    send("01", "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    send("0", "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    // R2: mixed random traffic against the model
    do_reset();
    for (int k = 0; k < 4000; k++)
      step(($urandom % 97) == 0, ($urandom % 4) != 0, $urandom % 2, "R2");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule